// File: doc/BRIEF.md
# Two-Wire Serial Target with Auto-Incrementing Register File

This block sits on a two-wire serial bus (I2C) as a target device at a fixed 7-bit address chosen by parameter. It samples the clock and data lines with the system clock, finds start, repeated start and stop conditions, and answers only the address it owns. Behind the bus sits a small register file of byte-wide registers that bus masters can write and read.

A write transaction carries the address byte with the direction bit clear, then one byte that selects a register, then any number of data bytes. Each data byte goes to the selected register, and the selection steps forward by one after each byte. A read transaction returns register contents starting from the current selection, which also steps forward after each byte. The selection is kept across a repeated start and across a stop. Masters therefore set it with a short write and then read back through a repeated start. A host-side port on the system clock reads and writes the same registers directly. When the host and the bus write one register in the same cycle, the host's value is kept.

The data line is driven only low: the block raises an enable and the pad pulls the line to ground. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, `sda_oe` is 0 and every register reads 0 through the host port.
- R2: A falling data line while the clock is high (start), or a rising data line while the clock is high (stop), discards any partly received byte. A start begins a fresh address byte. A stop releases the data line and idles the block, and a data byte cut short by it writes nothing.
- R3: The block samples the data line on a rising clock edge. It changes `sda_oe` only while the clock is low, so the line is steady for the whole high phase of every clock.
- R4: The first byte after a start arrives MSB first. Bits [7:1] are compared with `DEV_ADDR`, and bit 0 gives the direction: 1 is read, 0 is write. On a match the block pulls the data line low during the ninth clock.
- R5: When the address does not match, the block never pulls the data line low and changes no register until the next start.
- R6: In a write transaction, the first byte after the address loads the register selection from its low `PTR_W` bits and is not stored. Each later byte is stored in the selected register, the selection then advances by one, and every byte of the transaction is acknowledged.
- R7: The register selection wraps from register `2**PTR_W-1` to register 0, both for writes and for reads.
- R8: In a read transaction the block shifts out the selected register MSB first and advances the selection after each byte. The selection left by an earlier write phase or by an earlier transaction is used, across a repeated start or a stop.
- R9: When the master leaves the data line high in the acknowledge clock of a read byte, the block drives no further data until the next start.
- R10: `host_rdata` shows the register at `host_addr`, and `host_we` stores `host_wdata` there. A host write and a bus write to the same register in the same cycle leave the host value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus lines |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| host_we | input | 1 | Host write strobe |
| host_addr | input | PTR_W | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register contents at `host_addr` |

## Verification
A host write and the bus write that the eighth rising clock of a data byte triggers can land on the same register in the same system clock cycle. The bench provokes this by counting the two synchronizer stages after it drops the serial clock. It then raises the host strobe for exactly the cycle in which the target commits the byte. The outcome is judged at the ports: the register must hold the host value. The next bus byte must land in the following register, which shows that the pointer still advanced.

// File: rtl/i2cr_pkg.sv
// Shared types for the two-wire register target.
// Assumes byte-wide registers; the protocol fixes the byte width.
package i2cr_pkg;

    localparam int BYTE_W = 8;

    // Protocol phases of the target engine.
    typedef enum logic [2:0] {
        ST_IDLE,     // not addressed, waiting for a start
        ST_RX,       // shifting in an address or write byte
        ST_ACK_TX,   // target holds the line low in the ninth clock
        ST_TX,       // target shifts a read byte out
        ST_ACK_RX    // master's acknowledge clock after a read byte
    } i2cr_state_t;

endpackage

// File: rtl/i2cr_sync.sv
// Line conditioner: brings the asynchronous clock and data lines into the
// system clock domain and reports edges and bus conditions.
// Assumes the lines idle high; reset loads the idle level.
module i2cr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // bit 0 carries the clock line, bit 1 the data line
    logic [1:0] stage1_q, stage2_q, prev_q;

    // two-flop synchronizer plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= 2'b11;
            stage2_q <= 2'b11;
            prev_q   <= 2'b11;
        end else begin
            stage1_q <= {sda_i, scl_i};
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    // edges and bus conditions from synchronized samples only
    always_comb begin
        scl_s     = stage2_q[0];
        sda_s     = stage2_q[1];
        scl_rise  = stage2_q[0] && !prev_q[0];
        scl_fall  = !stage2_q[0] && prev_q[0];
        start_det = stage2_q[0] && prev_q[0] && prev_q[1] && !stage2_q[1];
        stop_det  = stage2_q[0] && prev_q[0] && !prev_q[1] && stage2_q[1];
    end
endmodule

// File: rtl/i2cr_regs.sv
// Register file with a host port and a bus port.
// Assumes one write per port per cycle; the host wins a same-index clash.
module i2cr_regs #(
    parameter int PTR_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_we,
    input  logic [PTR_W-1:0]           host_addr,
    input  logic [i2cr_pkg::BYTE_W-1:0] host_wdata,
    output logic [i2cr_pkg::BYTE_W-1:0] host_rdata,
    input  logic                       bus_we,
    input  logic [PTR_W-1:0]           bus_addr,
    input  logic [i2cr_pkg::BYTE_W-1:0] bus_wdata,
    output logic [i2cr_pkg::BYTE_W-1:0] bus_rdata
);
    localparam int NREGS = 1 << PTR_W;

    logic [i2cr_pkg::BYTE_W-1:0] mem [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        // one storage byte: host write first, then bus write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (host_we && host_addr == PTR_W'(g)) begin
                mem[g] <= host_wdata;
            end else if (bus_we && bus_addr == PTR_W'(g)) begin
                mem[g] <= bus_wdata;
            end
        end
    end

    // asynchronous read for both ports
    always_comb begin
        host_rdata = mem[host_addr];
        bus_rdata  = mem[bus_addr];
    end
endmodule

// File: rtl/i2cr_proto.sv
// Target protocol engine: frames bytes, matches the address, acknowledges,
// shifts read data and keeps the auto-incrementing register pointer.
// Assumes conditioned edges from i2cr_sync; drives the data line low only.
module i2cr_proto #(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         PTR_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_rise,
    input  logic                       scl_fall,
    input  logic                       start_det,
    input  logic                       stop_det,
    input  logic                       sda_s,
    input  logic [i2cr_pkg::BYTE_W-1:0] bus_rdata,
    output logic                       sda_oe,
    output logic                       bus_we,
    output logic [PTR_W-1:0]           bus_addr,
    output logic [i2cr_pkg::BYTE_W-1:0] bus_wdata
);
    import i2cr_pkg::*;

    i2cr_state_t       state_q;
    logic [3:0]        bit_cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              rx_full_q;
    logic              is_addr_q;
    logic              idx_pend_q;
    logic              rd_dir_q;
    logic              mack_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              oe_q;

    // bus write strobe: a complete data byte at the falling eighth clock
    always_comb begin
        bus_we    = (state_q == ST_RX) && rx_full_q && scl_fall && !is_addr_q && !idx_pend_q;
        bus_addr  = ptr_q;
        bus_wdata = shreg_q;
        sda_oe    = oe_q;
    end

    // protocol sequencing; start and stop override every phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            rx_full_q  <= 1'b0;
            is_addr_q  <= 1'b0;
            idx_pend_q <= 1'b0;
            rd_dir_q   <= 1'b0;
            mack_q     <= 1'b0;
            ptr_q      <= '0;
            oe_q       <= 1'b0;
        end else if (start_det) begin
            state_q    <= ST_RX;
            bit_cnt_q  <= '0;
            rx_full_q  <= 1'b0;
            is_addr_q  <= 1'b1;
            idx_pend_q <= 1'b0;
            oe_q       <= 1'b0;
        end else if (stop_det) begin
            state_q    <= ST_IDLE;
            rx_full_q  <= 1'b0;
            idx_pend_q <= 1'b0;
            oe_q       <= 1'b0;
        end else begin
            case (state_q)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                        if (bit_cnt_q == 4'd7) rx_full_q <= 1'b1;
                    end else if (scl_fall && rx_full_q) begin
                        rx_full_q <= 1'b0;
                        bit_cnt_q <= '0;
                        if (is_addr_q) begin
                            if (shreg_q[7:1] == DEV_ADDR) begin
                                oe_q     <= 1'b1;
                                rd_dir_q <= shreg_q[0];
                                state_q  <= ST_ACK_TX;
                            end else begin
                                state_q  <= ST_IDLE;
                            end
                        end else begin
                            oe_q    <= 1'b1;
                            state_q <= ST_ACK_TX;
                            if (idx_pend_q) begin
                                ptr_q      <= shreg_q[PTR_W-1:0];
                                idx_pend_q <= 1'b0;
                            end else begin
                                ptr_q <= ptr_q + 1'b1;
                            end
                        end
                    end
                end
                ST_ACK_TX: begin
                    if (scl_fall) begin
                        is_addr_q <= 1'b0;
                        bit_cnt_q <= '0;
                        if (is_addr_q && rd_dir_q) begin
                            shreg_q <= bus_rdata;
                            ptr_q   <= ptr_q + 1'b1;
                            oe_q    <= !bus_rdata[BYTE_W-1];
                            state_q <= ST_TX;
                        end else begin
                            oe_q    <= 1'b0;
                            state_q <= ST_RX;
                            if (is_addr_q) idx_pend_q <= 1'b1;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_cnt_q == 4'd8) begin
                            oe_q    <= 1'b0;
                            state_q <= ST_ACK_RX;
                        end else begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                            oe_q    <= !shreg_q[BYTE_W-2];
                        end
                    end
                end
                ST_ACK_RX: begin
                    if (scl_rise) begin
                        mack_q <= !sda_s;
                    end else if (scl_fall) begin
                        bit_cnt_q <= '0;
                        if (mack_q) begin
                            shreg_q <= bus_rdata;
                            ptr_q   <= ptr_q + 1'b1;
                            oe_q    <= !bus_rdata[BYTE_W-1];
                            state_q <= ST_TX;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    oe_q <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_regfile_target.sv
// Top of the two-wire register target: conditioner, protocol engine and
// register file. Assumes an external open-drain pad driven by sda_oe.
module i2c_regfile_target #(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         PTR_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             host_we,
    input  logic [PTR_W-1:0] host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata
);
    logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             bus_we;
    logic [PTR_W-1:0] bus_addr;
    logic [7:0]       bus_wdata, bus_rdata;

    i2cr_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cr_proto #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .bus_rdata (bus_rdata),
        .sda_oe    (sda_oe),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    i2cr_regs #(.PTR_W(PTR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata)
    );
endmodule

// File: rtl/i2cr_checker.sv
// Protocol and storage properties of the register target, bound to the top.
module i2cr_checker #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             stop_det,
    input logic             sda_oe,
    input logic             bus_we,
    input logic [PTR_W-1:0] bus_addr,
    input logic             host_we,
    input logic [PTR_W-1:0] host_addr,
    input logic [7:0]       host_wdata,
    input logic [7:0]       host_rdata
);
    // R3
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scl_s) |-> $stable(sda_oe));

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> (bus_addr == PTR_W'($past(bus_addr) + 1'b1)));

    // R10
    host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && bus_we && host_addr == bus_addr) |=>
            ((host_addr != $past(host_addr)) || (host_rdata == $past(host_wdata))));
endmodule

bind i2c_regfile_target i2cr_checker #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .stop_det   (stop_det),
    .sda_oe     (sda_oe),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
);

// File: tb/test_i2c_regfile_target.sv
`timescale 1ns/1ps
// Bench: bus master tasks, a behavioural register model and per-clock checks.
module test_i2c_regfile_target;
    localparam logic [6:0] ADDR  = 7'h2A;
    localparam int         PTR_W = 3;
    localparam int         NREGS = 8;
    localparam int         H     = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             scl_m = 1'b1, sda_m = 1'b1;
    logic             host_we = 1'b0;
    logic [PTR_W-1:0] host_addr = '0;
    logic [7:0]       host_wdata = '0;
    logic [7:0]       host_rdata;
    logic             sda_oe;
    wire              sda_line = sda_m & ~sda_oe;

    i2c_regfile_target #(.DEV_ADDR(ADDR), .PTR_W(PTR_W)) i_i2c_regfile_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    int          checks = 0, errors = 0, cyc = 0;
    logic [7:0]  model [NREGS];
    bit          cmp_en = 0, quiet = 0;
    string       quiet_req = "R5";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic hwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-clock comparison of the host view and of the quiet line
    always @(negedge clk) begin
        #2;
        if (rst_n && cmp_en)
            check(host_rdata == model[host_addr], "R10", "host view vs model",
                  host_rdata, model[host_addr]);
        if (rst_n && quiet)
            check(!sda_oe, quiet_req, "target drives line", sda_oe, 0);
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            report();
        end
    end

    task automatic sweep();
        cmp_en = 1;
        for (int i = 0; i < NREGS; i++) begin
            host_addr = PTR_W'(i);
            hwait(1);
        end
        cmp_en = 0;
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        host_addr = PTR_W'(a); host_wdata = d; host_we = 1'b1;
        hwait(1);
        host_we = 1'b0;
        model[a] = d;
    endtask

    task automatic host_check(input int a, input logic [7:0] exp, input string req);
        host_addr = PTR_W'(a);
        #2;
        check(host_rdata == exp, req, $sformatf("register %0d", a), host_rdata, exp);
        hwait(1);
    endtask

    task automatic start_c();
        sda_m = 1; scl_m = 1; hwait(H);
        sda_m = 0; hwait(H);
        scl_m = 0; hwait(H);
    endtask

    task automatic rstart_c();
        sda_m = 1; hwait(H);
        scl_m = 1; hwait(H);
        sda_m = 0; hwait(H);
        scl_m = 0; hwait(H);
    endtask

    task automatic stop_c();
        sda_m = 0; hwait(H);
        scl_m = 1; hwait(H);
        sda_m = 1; hwait(H);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; hwait(H);
        scl_m = 1; hwait(H);
        scl_m = 0; hwait(H);
    endtask

    task automatic recv_bit(output bit b);
        sda_m = 1; hwait(H);
        scl_m = 1; hwait(H/2);
        b = sda_line;
        hwait(H/2);
        // R3: line steady over the high phase
        check(sda_line == b, "R3", "data moved while clock high", sda_line, b);
        scl_m = 0; hwait(H);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(a);
        ack = !a;
    endtask

    task automatic read_byte(output logic [7:0] b, input bit mack);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            b[i] = x;
        end
        send_bit(!mack);
    endtask

    // last bit's falling edge lines up a host write with the bus commit
    task automatic write_byte_collide(input logic [7:0] b, input int ha,
                                      input logic [7:0] hd, output bit ack);
        bit a;
        for (int i = 7; i >= 1; i--) send_bit(b[i]);
        sda_m = b[0]; hwait(H);
        scl_m = 1; hwait(H);
        scl_m = 0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        host_addr = PTR_W'(ha); host_wdata = hd; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        hwait(H - 2);
        recv_bit(a);
        ack = !a;
    endtask

    initial begin
        bit         ack;
        logic [7:0] rd;
        for (int i = 0; i < NREGS; i++) model[i] = 8'h00;

        hwait(4);
        rst_n = 1'b1;
        hwait(4);
        // R1: reset state
        check(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
        for (int i = 0; i < NREGS; i++) host_check(i, 8'h00, "R1");

        // R6/R7: write with index and wrap past the last register
        start_c();
        write_byte({ADDR, 1'b0}, ack); check(ack, "R4", "address write ack", ack, 1);
        write_byte(8'h05, ack);        check(ack, "R6", "index ack", ack, 1);
        write_byte(8'hA1, ack);        check(ack, "R6", "data ack", ack, 1);
        write_byte(8'hB2, ack);        check(ack, "R6", "data ack", ack, 1);
        write_byte(8'hC3, ack);        check(ack, "R6", "data ack", ack, 1);
        write_byte(8'hD4, ack);        check(ack, "R7", "data ack after wrap", ack, 1);
        stop_c();
        model[5] = 8'hA1; model[6] = 8'hB2; model[7] = 8'hC3; model[0] = 8'hD4;
        sweep();
        host_check(5, 8'hA1, "R6");
        host_check(0, 8'hD4, "R7");
        host_check(4, 8'h00, "R6");

        // R10 host writes, then R8 read through a repeated start
        host_write(2, 8'h11); host_write(3, 8'h22); host_write(4, 8'h33);
        host_check(3, 8'h22, "R10");
        start_c();
        write_byte({ADDR, 1'b0}, ack); check(ack, "R4", "address write ack", ack, 1);
        write_byte(8'h02, ack);        check(ack, "R6", "index ack", ack, 1);
        rstart_c();
        write_byte({ADDR, 1'b1}, ack); check(ack, "R4", "address read ack", ack, 1);
        read_byte(rd, 1'b1); check(rd == 8'h11, "R8", "read byte 0", rd, 8'h11);
        read_byte(rd, 1'b1); check(rd == 8'h22, "R8", "read byte 1", rd, 8'h22);
        read_byte(rd, 1'b0); check(rd == 8'h33, "R8", "read byte 2", rd, 8'h33);
        // R9: after NACK the target stays off the line
        quiet_req = "R9"; quiet = 1;
        read_byte(rd, 1'b0); check(rd == 8'hFF, "R9", "no data after nack", rd, 8'hFF);
        quiet = 0;
        stop_c();
        sweep();

        // R8: pointer persists across a stop
        start_c();
        write_byte({ADDR, 1'b1}, ack); check(ack, "R4", "address read ack", ack, 1);
        read_byte(rd, 1'b0); check(rd == 8'hA1, "R8", "pointer kept after stop", rd, 8'hA1);
        stop_c();

        // R5: foreign addresses, write and read direction
        quiet_req = "R5"; quiet = 1;
        start_c();
        write_byte({7'h2B, 1'b0}, ack); check(!ack, "R5", "foreign write ack", ack, 0);
        write_byte(8'h03, ack);         check(!ack, "R5", "foreign index ack", ack, 0);
        write_byte(8'hEE, ack);         check(!ack, "R5", "foreign data ack", ack, 0);
        stop_c();
        start_c();
        write_byte({7'h15, 1'b1}, ack); check(!ack, "R5", "foreign read ack", ack, 0);
        read_byte(rd, 1'b0); check(rd == 8'hFF, "R5", "foreign read data", rd, 8'hFF);
        stop_c();
        quiet = 0;
        sweep();

        // R2: repeated start mid-byte reframes the address
        start_c();
        send_bit(1); send_bit(0); send_bit(1); send_bit(1);
        rstart_c();
        write_byte({ADDR, 1'b0}, ack); check(ack, "R2", "address after restart", ack, 1);
        write_byte(8'h01, ack);        check(ack, "R6", "index ack", ack, 1);
        write_byte(8'h5A, ack);        check(ack, "R6", "data ack", ack, 1);
        stop_c();
        model[1] = 8'h5A;
        host_check(1, 8'h5A, "R2");

        // R2: stop inside a data byte stores nothing
        start_c();
        write_byte({ADDR, 1'b0}, ack); check(ack, "R4", "address write ack", ack, 1);
        write_byte(8'h06, ack);        check(ack, "R6", "index ack", ack, 1);
        send_bit(0); send_bit(0); send_bit(0); send_bit(0);
        stop_c();
        check(sda_oe == 1'b0, "R2", "released after stop", sda_oe, 0);
        host_check(6, 8'hB2, "R2");
        sweep();

        // R10: host and bus write register 0 in the same cycle
        start_c();
        write_byte({ADDR, 1'b0}, ack); check(ack, "R4", "address write ack", ack, 1);
        write_byte(8'h00, ack);        check(ack, "R6", "index ack", ack, 1);
        write_byte_collide(8'h77, 0, 8'hEE, ack);
        check(ack, "R10", "collision byte ack", ack, 1);
        write_byte(8'h99, ack);        check(ack, "R6", "data ack", ack, 1);
        stop_c();
        model[0] = 8'hEE; model[1] = 8'h99;
        host_check(0, 8'hEE, "R10");
        host_check(1, 8'h99, "R6");

        // R7: read wraps from the last register to register 0
        start_c();
        write_byte({ADDR, 1'b0}, ack); check(ack, "R4", "address write ack", ack, 1);
        write_byte(8'h07, ack);        check(ack, "R6", "index ack", ack, 1);
        rstart_c();
        write_byte({ADDR, 1'b1}, ack); check(ack, "R4", "address read ack", ack, 1);
        read_byte(rd, 1'b1); check(rd == 8'hC3, "R7", "read last register", rd, 8'hC3);
        read_byte(rd, 1'b0); check(rd == 8'hEE, "R7", "read after wrap", rd, 8'hEE);
        stop_c();
        sweep();

        report();
    end
endmodule